// File: doc/BRIEF.md
# Pump Start Failure Alarm

This block supervises the start of a set of pumps. For each pump it watches the run command that the controller sends to the motor and the running feedback that comes back from the motor. While a pump is commanded to run and its feedback is absent, a per-pump timer counts pulses of a slow timebase tick. When the count reaches the timeout, the pump's alarm output turns on and stays on.

No operator acknowledge is needed to clear the alarm. It clears itself as soon as running feedback arrives, because that shows the pump has started. It also clears on reset. If the command is withdrawn before the timeout, the timer is discarded and no alarm is raised. If the command is withdrawn after the alarm has latched, the alarm stays on. Each pump has its own timer and latch, with nothing shared between them.

The timeout is a parameter counted in tick pulses. With the default 10 Hz tick, the default of 50 ticks gives five seconds.

Top module: `start_fail_alarm`

## Requirements
- R1: While rst_ni is low, every alarm_o bit is 0 and every timer is cleared. After reset is released, a full TIMEOUT_TICKS ticks are needed before any alarm can turn on.
- R2: Suppose pump p has cmd_i[p]=1 and fb_i[p]=0 throughout, and tick_i is high on TIMEOUT_TICKS clock edges. Then alarm_o[p] becomes 1 in the cycle after the edge that carries the last of those ticks.
- R3: With cmd_i[p]=1 and fb_i[p]=0, fewer than TIMEOUT_TICKS counted ticks leave alarm_o[p] at 0.
- R4: A clock edge with cmd_i[p]=0 and fb_i[p]=0 clears pump p's timer. A later start attempt again needs a full TIMEOUT_TICKS ticks to raise the alarm.
- R5: A clock edge with fb_i[p]=1 clears alarm_o[p] in the next cycle and clears pump p's timer, whatever cmd_i[p] is.
- R6: Once alarm_o[p] is 1, it stays 1 while fb_i[p] stays 0, even if cmd_i[p] drops or ticks continue.
- R7: Each pump's timer and alarm depend only on that pump's cmd_i and fb_i bits and on the shared tick_i. Activity on one pump never changes another pump's alarm_o.
- R8: A tick counts toward the timeout only on an edge where cmd_i[p]=1 and fb_i[p]=0. Clock edges without a tick never advance the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase pulse, one clock wide, shared by all pumps |
| cmd_i | input | N_PUMPS | Run command per pump, 1 = commanded to run |
| fb_i | input | N_PUMPS | Running feedback per pump, 1 = motor running |
| alarm_o | output | N_PUMPS | Start failure alarm per pump, 1 = failed to start |

## Verification
A timer that is off by one shows up as an alarm one tick early or one tick late. The bench therefore probes the exact boundary tick, and also a run one tick short of it. A timer that is not cleared when the command is dropped or when feedback arrives lets a later, shorter attempt raise the alarm. This is seen as soon as the shortened attempt reaches its last tick. A latch with the wrong priority, or lanes that leak into each other, changes alarm_o in the cycle after the offending edge. A cycle-by-cycle model compared under random stimulus catches this within one clock.

// File: rtl/start_fail_pkg.sv
package start_fail_pkg;
  // Counter width needed to hold values 0..limit
  function automatic int unsigned cnt_width(input int unsigned limit);
    int unsigned w;
    w = 1;
    while ((1 << w) <= limit) w++;
    return w;
  endfunction
endpackage

// File: rtl/sfa_timer.sv
module sfa_timer #(
  parameter int unsigned LIMIT = 50,
  parameter int unsigned CNT_W = start_fail_pkg::cnt_width(LIMIT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic hit_o
);
  localparam logic [CNT_W-1:0] LastVal = CNT_W'(LIMIT - 1);
  localparam logic [CNT_W-1:0] TopVal  = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  // Set pulse: the tick that completes the timeout
  assign hit_o = run_i && tick_i && (cnt_q == LastVal);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != TopVal)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sfa_latch.sv
module sfa_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (clr_i)  q_o <= 1'b0;  // feedback wins
    else if (set_i)  q_o <= 1'b1;
  end
endmodule

// File: rtl/start_fail_alarm.sv
module start_fail_alarm #(
  parameter int unsigned N_PUMPS       = 2,
  parameter int unsigned TIMEOUT_TICKS = 50
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [N_PUMPS-1:0] cmd_i,
  input  logic [N_PUMPS-1:0] fb_i,
  output logic [N_PUMPS-1:0] alarm_o
);
  localparam int unsigned CntW = start_fail_pkg::cnt_width(TIMEOUT_TICKS);

  logic [N_PUMPS-1:0] run_w;
  logic [N_PUMPS-1:0] hit_w;

  for (genvar p = 0; p < N_PUMPS; p++) begin : g_pump
    assign run_w[p] = cmd_i[p] && !fb_i[p];

    sfa_timer #(
      .LIMIT (TIMEOUT_TICKS),
      .CNT_W (CntW)
    ) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_w[p]),
      .tick_i (tick_i),
      .hit_o  (hit_w[p])
    );

    sfa_latch u_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (hit_w[p]),
      .clr_i  (fb_i[p]),
      .q_o    (alarm_o[p])
    );
  end
endmodule

// File: rtl/start_fail_alarm_chk.sv
module start_fail_alarm_chk #(
  parameter int unsigned N_PUMPS = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic [N_PUMPS-1:0] cmd_i,
  input logic [N_PUMPS-1:0] fb_i,
  input logic [N_PUMPS-1:0] alarm_o
);
  for (genvar p = 0; p < N_PUMPS; p++) begin : g_chk
    // R5
    fb_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fb_i[p] |=> !alarm_o[p]);
    // R2
    rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(alarm_o[p]) |-> $past(cmd_i[p] && !fb_i[p] && tick_i));
    // R6
    alarm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alarm_o[p] && !fb_i[p]) |=> alarm_o[p]);
    // R4
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cmd_i[p] && !alarm_o[p]) |=> !alarm_o[p]);
    // R8
    no_tick_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !alarm_o[p]) |=> !alarm_o[p]);
  end
endmodule

bind start_fail_alarm start_fail_alarm_chk #(.N_PUMPS(N_PUMPS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .cmd_i   (cmd_i),
  .fb_i    (fb_i),
  .alarm_o (alarm_o)
);

// File: tb/start_fail_alarm_test.sv
module start_fail_alarm_test;
  localparam int NP  = 2;
  localparam int LIM = 50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [NP-1:0] cmd = '0;
  logic [NP-1:0] fb = '0;
  logic [NP-1:0] alarm;

  int checks = 0;
  int errors = 0;

  // Reference model state
  int            m_cnt [NP];
  logic [NP-1:0] m_alarm;

  always #10 clk = ~clk;  // 50 MHz

  start_fail_alarm #(.N_PUMPS(NP), .TIMEOUT_TICKS(LIM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .cmd_i(cmd), .fb_i(fb), .alarm_o(alarm)
  );

  function automatic logic next_alarm(input logic a, input logic c, input logic f,
                                      input logic t, input int n);
    if (f) return 1'b0;
    if (c && t && n == LIM - 1) return 1'b1;
    return a;
  endfunction

  function automatic int next_cnt(input logic c, input logic f, input logic t, input int n);
    if (f || !c) return 0;
    if (t && n < LIM) return n + 1;
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) m_cnt[p] <= 0;
      m_alarm <= '0;
    end else begin
      for (int p = 0; p < NP; p++) begin
        m_alarm[p] <= next_alarm(m_alarm[p], cmd[p], fb[p], tick, m_cnt[p]);
        m_cnt[p]   <= next_cnt(cmd[p], fb[p], tick, m_cnt[p]);
      end
    end
  end

  task automatic check(input string tag, input logic [NP-1:0] got, input logic [NP-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: alarm=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  // Drive after negedge, let one posedge pass, return at next negedge
  task automatic step(input logic [NP-1:0] c, input logic [NP-1:0] f, input logic t);
    cmd = c; fb = f; tick = t;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input logic [NP-1:0] c, input logic [NP-1:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      step(c, f, 1'b1);
      step(c, f, 1'b0);
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: alarm=%b expected=done", alarm);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    check("R1 reset", alarm, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 one tick short, R2 exact boundary, R7 other lane quiet
    ticks(2'b01, 2'b00, LIM - 1);
    check("R3 short run", alarm, 2'b00);
    step(2'b01, 2'b00, 1'b1);
    check("R2 boundary tick", alarm, 2'b01);
    check("R7 lane isolation", alarm & 2'b10, 2'b00);

    // R6 command removed, alarm holds
    ticks(2'b00, 2'b00, 5);
    check("R6 hold after cmd drop", alarm, 2'b01);

    // R5 feedback clears
    step(2'b01, 2'b01, 1'b0);
    check("R5 feedback clear", alarm, 2'b00);

    // R4 drop resets timer
    ticks(2'b10, 2'b00, 30);
    step(2'b00, 2'b00, 1'b0);
    ticks(2'b10, 2'b00, LIM - 1);
    check("R4 restart needs full count", alarm, 2'b00);
    step(2'b10, 2'b00, 1'b1);
    check("R4 restart full count", alarm, 2'b10);
    step(2'b00, 2'b10, 1'b0);
    check("R5 clear lane 1", alarm, 2'b00);

    // R8 ticks with feedback present do not count; idle clocks do not count
    ticks(2'b11, 2'b11, LIM + 10);
    check("R8 ticks under feedback", alarm, 2'b00);
    for (int i = 0; i < 3 * LIM; i++) step(2'b11, 2'b00, 1'b0);
    check("R8 no-tick clocks", alarm, 2'b00);
    ticks(2'b11, 2'b00, LIM - 1);
    check("R8 count from zero", alarm, 2'b00);
    step(2'b11, 2'b00, 1'b1);
    check("R2 both lanes", alarm, 2'b11);

    // R1 reset clears a latched alarm and the timers
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears alarm", alarm, 2'b00);
    rst_n = 1'b1;
    ticks(2'b11, 2'b00, LIM - 1);
    check("R1 timer cleared by reset", alarm, 2'b00);
    ticks(2'b00, 2'b11, 1);

    // Random phase against the model
    for (int i = 0; i < 20000; i++) begin
      logic [NP-1:0] c;
      logic [NP-1:0] f;
      c = cmd; f = fb;
      for (int p = 0; p < NP; p++) begin
        if ($urandom_range(0, 199) == 0) c[p] = ~c[p];
        if ($urandom_range(0, 299) == 0) f[p] = 1'b1;
        else if ($urandom_range(0, 9) == 0) f[p] = 1'b0;
      end
      step(c, f, ($urandom_range(0, 3) == 0));
      check("R7 random vs model", alarm, m_alarm);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule